// File: doc/BRIEF.md
# Bit-Reversed Index Stepper

This block advances an index in bit-reversed order, the order an FFT working in place uses to walk its buffer. Operand A carries the current index and operand B carries a mask. Only the bits that the mask selects take part in the step. Every other bit of A appears unchanged in the result. A power-of-two buffer size is chosen by putting ones in the low bits of B.

Inside the masked field the step is an increment that treats the most significant bit as the least significant one. The block mirrors the word, adds one, and mirrors the sum back. Before the first mirror, every bit outside the mask is forced to one, so the carry runs only through masked positions and is lost off the end of the word.

One register stage holds the result. A two-state output machine tracks it: `ST_EMPTY` means no result is presented and `ST_FULL` means a result is presented. The transition `take` goes to `ST_FULL` when `in_valid` is high, and the transition `drain` goes to `ST_EMPTY` when `in_valid` is low. Synchronous reset forces `ST_EMPTY` and clears the result register.

Top module: `bitrev_stepper`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `out_index` is 0.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low.
- R3: Every result bit whose mask bit is 0 equals the corresponding bit of `in_index`.
- R4: The masked field of the result is the bit-reversed increment of the masked field of `in_index`. The carry enters at the highest masked bit and moves toward lower masked bits, passing over unmasked positions. For mask 0x0000FFFF, index 0 steps to 0x00008000.
- R5: When every masked bit of `in_index` is 1, every masked bit of the result is 0.
- R6: With mask 0, the result equals `in_index`.
- R7: In a cycle with `in_valid` low, `out_index` keeps its previous value.
- R8: With mask 0x0000FFFF and the result fed back as the next index, starting at 0, the index first returns to 0 after exactly 65536 steps, so every 16-bit index is visited once.
- R9: Masks whose ones are not contiguous follow the R4 carry rule, with the carry skipping unmasked positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| in_index | input | 32 | Current index (operand A) |
| in_mask | input | 32 | Field mask (operand B) |
| out_valid | output | 1 | Result is valid |
| out_index | output | 32 | Stepped index |

## Verification
The hardest case to reach from the ports is the wrap: a masked field that is all ones, which must clear to zero while the carry is absorbed outside the field. A 16-bit field only gets there after a long walk. The bench therefore feeds each result back as the next index, so one run passes through every state of the 16-bit field, including the wrap, and confirms that the cycle closes at exactly 65536 steps. Narrow fields are also swept exhaustively under random upper bits, and sparse masks are checked against a reference that walks the carry bit by bit.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_t;
endpackage

// File: rtl/bitrev_mirror.sv
// Full word mirror: the two nibbles of each byte swap places with their
// bits reversed, and the bytes trade places end for end.
module bitrev_mirror #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int NBYTES = WORD_W / 8;

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            for (genvar n = 0; n < 2; n++) begin : g_nib
                for (genvar k = 0; k < 4; k++) begin : g_bit
                    assign dout[(NBYTES-1-b)*8 + (1-n)*4 + (3-k)] = din[b*8 + n*4 + k];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bitrev_step.sv
module bitrev_step #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] idx,
    input  logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] nxt
);
    localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

    logic [WORD_W-1:0] forced;
    logic [WORD_W-1:0] fwd;
    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] back;

    // Unmasked positions set to one so the carry skips over them.
    assign forced = idx | ~mask;

    bitrev_mirror #(.WORD_W(WORD_W)) mir_fwd_i (.din(forced), .dout(fwd));

    assign sum = fwd + ONE;

    bitrev_mirror #(.WORD_W(WORD_W)) mir_back_i (.din(sum), .dout(back));

    assign nxt = (idx & ~mask) | (back & mask);

    always_comb begin
        if (((idx & mask) == mask) && (mask != '0)) begin
            assert_wrap_R5: assert ((nxt & mask) == '0);
        end
        if (mask == '0) begin
            assert_zero_mask_R6: assert (nxt == idx);
        end
    end
endmodule

// File: rtl/bitrev_stepper.sv
module bitrev_stepper
    import bitrev_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_index,
    input  logic [WORD_W-1:0] in_mask,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_index
);
    out_state_t        state_q, state_d;
    logic [WORD_W-1:0] step_res;
    logic [WORD_W-1:0] res_q;

    bitrev_step #(.WORD_W(WORD_W)) step_i (
        .idx  (in_index),
        .mask (in_mask),
        .nxt  (step_res)
    );

    // Next-state logic: take on valid input, drain otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;
            ST_FULL:  if (!in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Result register: captured only on valid input.
    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (in_valid) res_q <= step_res;
    end

    // Outputs.
    always_comb begin
        out_valid = (state_q == ST_FULL);
        out_index = res_q;
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_index));
    assert_passthru_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (((out_index ^ $past(in_index)) & ~$past(in_mask)) == '0));
endmodule

// File: tb/bitrev_stepper_tb_top.sv
`timescale 1ns/1ps
module bitrev_stepper_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_index = '0;
    logic [31:0] in_mask = '0;
    logic        out_valid;
    logic [31:0] out_index;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bitrev_stepper dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_index(in_index), .in_mask(in_mask),
        .out_valid(out_valid), .out_index(out_index)
    );

    // Carry enters at the highest masked bit and moves downward.
    function automatic logic [31:0] ref_step(input logic [31:0] a, input logic [31:0] m);
        logic [31:0] r = a;
        for (int i = 31; i >= 0; i--) begin
            if (m[i]) begin
                if (r[i]) r[i] = 1'b0;
                else begin r[i] = 1'b1; break; end
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operand pair, sample the result one cycle later.
    task automatic step(input logic [31:0] a, input logic [31:0] m, output logic [31:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_index = a; in_mask = m;
        @(negedge clk);
        in_valid = 1'b0;
        r = out_index;
        check("R2 valid", {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        logic [31:0] r, idx, held;
        repeat (3) @(negedge clk);
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 index", out_index, 32'd0);
        rst = 1'b0;

        step(32'h0, 32'h0000FFFF, r);
        check("R4 first step", r, 32'h00008000);
        step(32'h12348000, 32'h0000FFFF, r);
        check("R4 second step", r, 32'h12344000);
        check("R3 upper bits", r & 32'hFFFF0000, 32'h12340000);

        // R2 drop and R7 hold
        held = r;
        @(negedge clk);
        in_index = 32'hDEADBEEF; in_mask = 32'hFFFFFFFF;
        @(negedge clk);
        check("R2 drop", {31'd0, out_valid}, 32'd0);
        check("R7 hold", out_index, held);

        step(32'hCAFE_FFFF, 32'h0000FFFF, r);
        check("R5 wrap", r, 32'hCAFE0000);
        step(32'hFFFFFFFF, 32'hFFFFFFFF, r);
        check("R5 full wrap", r, 32'h0);
        step(32'h89ABCDEF, 32'h0, r);
        check("R6 zero mask", r, 32'h89ABCDEF);

        // R9 sparse masks
        for (int t = 0; t < 200; t++) begin
            logic [31:0] a = $urandom;
            logic [31:0] m = $urandom;
            step(a, m, r);
            check("R9 sparse", r, ref_step(a, m));
            check("R3 sparse passthru", r & ~m, a & ~m);
        end

        // R4 exhaustive narrow fields under random upper bits
        for (int w = 1; w <= 8; w++) begin
            for (int v = 0; v < (1 << w); v++) begin
                logic [31:0] m = (32'd1 << w) - 32'd1;
                logic [31:0] a = ($urandom & ~m) | v;
                step(a, m, r);
                check("R4 sweep", r, ref_step(a, m));
            end
        end

        // R8 full 16-bit walk with feedback
        idx = 32'h5A5A0000;
        for (int k = 0; k < 65536; k++) begin
            step(idx, 32'h0000FFFF, r);
            check("R8 walk", r, ref_step(idx, 32'h0000FFFF));
            if (k < 65535 && r[15:0] == 16'h0) check("R8 early return", r, 32'h5A5A0001);
            idx = r;
        end
        check("R8 return", idx, 32'h5A5A0000);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R1 re-reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 re-reset index", out_index, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule